// File: doc/BRIEF.md
# Dual-Mode Burst Address Generator

This block supplies the word address for a synchronous burst memory. A start from either of two sources captures the external address as the base of a new burst. Advance pulses then step the two low-order address bits through four beats. The upper bits do not change during the burst. The stepping order is fixed for the whole burst and is chosen by a mode input when the burst starts. Linear order counts up and wraps at the four-beat boundary. Interleaved order XORs the starting field with a beat count.

One start input comes from the processor and only takes effect while chip enable is high. The other comes from the memory controller and takes effect whatever chip enable is. A new address can be loaded on every clock, so bursts can be cut short or run back to back without losing a cycle. After the fourth advance the burst ends: the low field returns to its starting value and the active flag drops.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is asserted (rst_n low), addr_out is all zeros and burst_act is 0.
- R2: A load happens at a rising edge when (start_cpu and ce) or start_ctl is 1. After that edge, addr_out equals the addr_in value sampled at that edge and burst_act is 1.
- R3: start_cpu has no effect while ce is 0. start_ctl loads regardless of ce. When both strobes load in the same cycle, exactly one load of addr_in takes place.
- R4: In linear order (order_lin = 1 at load time), each edge with adv = 1 while burst_act = 1 raises addr_out[1:0] by one, wrapping from 3 to 0.
- R5: In interleaved order (order_lin = 0 at load time), addr_out[1:0] equals the starting field XOR a beat count that runs 0, 1, 2, 3. For example, start 1 gives 1, 0, 3, 2.
- R6: addr_out above bit 1 stays at the captured value until the next load.
- R7: At an edge with adv = 0 and no load, addr_out and burst_act keep their values.
- R8: The fourth advance of a burst returns addr_out[1:0] to its starting value and clears burst_act. Advances while burst_act is 0 leave addr_out unchanged.
- R9: The order is captured at load. A change on order_lin during a burst does not alter the sequence of that burst.
- R10: Loads may occur on consecutive edges, and each one takes effect at once. A load in the same cycle as adv takes precedence over the advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_in | input | AW | External address to capture |
| start_cpu | input | 1 | Processor-side burst start, qualified by ce |
| start_ctl | input | 1 | Controller-side burst start |
| adv | input | 1 | Advance to the next beat |
| ce | input | 1 | Chip enable |
| order_lin | input | 1 | 1 = linear order, 0 = interleaved order (default) |
| addr_out | output | AW | Current word address |
| burst_act | output | 1 | Burst in progress |

## Verification
The assertions check, on every cycle, the rules that need only one edge of history:
- a load captures the address and sets the active flag;
- the upper bits stay put between loads;
- idle cycles hold both outputs;
- a processor start with chip enable low is ignored;
- a linear advance raises the low field by one.

The bench scenarios are needed for anything that depends on where the burst started:
- the complete interleaved sequences and the return to the starting field after four beats;
- the order being captured at load rather than followed live;
- priority between the two strobes, and a load overriding an advance, seen through the loaded address.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_in,
  input  logic          start_cpu,
  input  logic          start_ctl,
  input  logic          adv,
  input  logic          ce,
  input  logic          order_lin,
  output logic [AW-1:0] addr_out,
  output logic          burst_act
);
  localparam int FW = 2;

  logic [AW-1:0] base_q;
  logic [FW-1:0] beat_q;
  logic          lin_q;
  logic          act_q;
  logic [FW-1:0] low;

  wire load = (start_cpu & ce) | start_ctl;
  wire step = adv & act_q & ~load;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      beat_q <= '0;
      lin_q  <= 1'b0;
      act_q  <= 1'b0;
    end else if (load) begin
      base_q <= addr_in;
      beat_q <= '0;
      lin_q  <= order_lin;
      act_q  <= 1'b1;
    end else if (step) begin
      beat_q <= beat_q + 1'b1;
      if (beat_q == '1) act_q <= 1'b0;
    end
  end

  assign low       = lin_q ? base_q[FW-1:0] + beat_q : base_q[FW-1:0] ^ beat_q;
  assign addr_out  = {base_q[AW-1:FW], low};
  assign burst_act = act_q;
endmodule

// File: rtl/burst_addr_gen_chk.sv
module burst_addr_gen_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] addr_in,
  input logic          start_cpu,
  input logic          start_ctl,
  input logic          adv,
  input logic          ce,
  input logic [AW-1:0] addr_out,
  input logic          burst_act,
  input logic          lin_q
);
  logic ld;
  assign ld = (start_cpu && ce) || start_ctl;

  p_load_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (addr_out == $past(addr_in)) && burst_act);

  p_upper_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> $stable(addr_out[AW-1:2]));

  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !adv) |=> $stable(addr_out) && $stable(burst_act));

  p_cpu_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cpu && !ce && !start_ctl && !adv) |=> $stable(addr_out));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && adv && burst_act && lin_q) |=> addr_out[1:0] == $past(addr_out[1:0]) + 2'd1);

  p_idle_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !burst_act) |=> $stable(addr_out) && !burst_act);
endmodule

bind burst_addr_gen burst_addr_gen_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .start_cpu(start_cpu),
  .start_ctl(start_ctl), .adv(adv), .ce(ce), .addr_out(addr_out),
  .burst_act(burst_act), .lin_q(lin_q)
);

// File: tb/burst_addr_gen_bench.sv
module burst_addr_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ain = '0;
  logic        scpu = 1'b0, sctl = 1'b0, adv = 1'b0, ce = 1'b0, lin = 1'b0;
  logic [15:0] aout;
  logic        act;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  burst_addr_gen #(.AW(16)) u_burst_addr_gen (
    .clk(clk), .rst_n(rst_n), .addr_in(ain), .start_cpu(scpu), .start_ctl(sctl),
    .adv(adv), .ce(ce), .order_lin(lin), .addr_out(aout), .burst_act(act)
  );

  task automatic cyc(input bit c, input bit t, input bit e, input bit a, input bit l,
                     input logic [15:0] ad);
    @(negedge clk);
    scpu = c; sctl = t; ce = e; adv = a; lin = l; ain = ad;
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [15:0] ea, input bit eact);
    n_chk++;
    if (aout !== ea || act !== eact) begin
      n_err++;
      $display("FAIL %s: addr=%h act=%b expected addr=%h act=%b", tag, aout, act, ea, eact);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 reset", 16'h0000, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc(0, 0, 0, 1, 0, 16'hFFFF);
    chk("R8 adv idle after reset", 16'h0000, 1'b0);
  endtask

  task automatic t_linear();
    cyc(1, 0, 1, 0, 1, 16'h1232); chk("R2 cpu load", 16'h1232, 1'b1);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R4 linear b1", 16'h1233, 1'b1);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R4 linear wrap", 16'h1230, 1'b1);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R4 linear b3", 16'h1231, 1'b1);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R8 end linear", 16'h1232, 1'b0);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R8 adv ignored", 16'h1232, 1'b0);
  endtask

  task automatic t_interleave();
    cyc(0, 1, 0, 0, 0, 16'hABC1); chk("R2 ctl load", 16'hABC1, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R5 il b1", 16'hABC0, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R5 il b2 R6", 16'hABC3, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R5 il b3", 16'hABC2, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R8 end il", 16'hABC1, 1'b0);
    cyc(0, 1, 0, 0, 0, 16'h00F2); chk("R2 il load2", 16'h00F2, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R5 il start2 b1", 16'h00F3, 1'b1);
    cyc(0, 0, 0, 1, 0, 16'h0000); chk("R5 il start2 b2", 16'h00F0, 1'b1);
  endtask

  task automatic t_hold();
    cyc(1, 0, 1, 0, 0, 16'h0F03); chk("R2 load hold", 16'h0F03, 1'b1);
    cyc(0, 0, 1, 1, 0, 16'h0000); chk("R5 il start3", 16'h0F02, 1'b1);
    for (int i = 0; i < 3; i++) begin
      cyc(0, 0, 1, 0, 1, 16'hFFFF); chk("R7 hold", 16'h0F02, 1'b1);
    end
  endtask

  task automatic t_strobes();
    cyc(1, 0, 0, 0, 0, 16'h5555); chk("R3 cpu gated", 16'h0F02, 1'b1);
    cyc(0, 1, 0, 0, 0, 16'h5556); chk("R3 ctl no ce", 16'h5556, 1'b1);
    cyc(1, 1, 1, 0, 0, 16'h7777); chk("R3 both", 16'h7777, 1'b1);
    cyc(0, 0, 1, 1, 0, 16'h0000); chk("R3 both then adv", 16'h7776, 1'b1);
  endtask

  task automatic t_mode_latch();
    cyc(1, 0, 1, 0, 1, 16'h0001); chk("R9 load lin", 16'h0001, 1'b1);
    cyc(0, 0, 1, 1, 0, 16'h0000); chk("R9 mode held", 16'h0002, 1'b1);
    cyc(0, 0, 1, 1, 0, 16'h0000); chk("R9 mode held b2", 16'h0003, 1'b1);
  endtask

  task automatic t_b2b();
    cyc(1, 0, 1, 1, 1, 16'h1000); chk("R10 b2b 1", 16'h1000, 1'b1);
    cyc(0, 1, 0, 1, 0, 16'h2001); chk("R10 b2b 2", 16'h2001, 1'b1);
    cyc(1, 0, 1, 1, 1, 16'h3002); chk("R10 b2b 3", 16'h3002, 1'b1);
    cyc(0, 0, 1, 1, 1, 16'h0000); chk("R10 then adv", 16'h3003, 1'b1);
  endtask

  initial begin
    t_reset();
    t_linear();
    t_interleave();
    t_hold();
    t_strobes();
    t_mode_latch();
    t_b2b();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule